// File: doc/BRIEF.md
# Toggle-Armed Analog Supply Sequencer

This block gates two analog supply enables: one for a low-voltage pair and one for a high-voltage rail. A level on a command line cannot turn either enable on. Each enable is armed only after its own command line has produced a fixed number of rising edges. Both command lines are asynchronous. Each one passes through a two-flop synchronizer and then a rising-edge detector, and every edge advances a saturating counter. The high-voltage counter counts only while the low-voltage side is armed. Any clear of the low-voltage side also wipes the high-voltage side. High voltage can therefore only come up after low voltage is already up.

Supply-health inputs are sampled on every clock: reference-supply good, comparator-window good, the active-low utility reset, and a remote reset request. A digital-supply-good input joins them only when its check enable is set. Any one of these faults clears both counters and both enables together. Two bench override inputs force the corresponding enable on for test. The digital supply itself is not switched by this block.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `lv_en_o` goes high only once `TOGGLE_COUNT` (default 128) rising edges have been counted on `lv_toggle_i`. An edge is counted on the third rising clock edge after the input goes high, because of the two synchronizer flops plus the counter register. After 127 edges `lv_en_o` is still low.
- R2: While the low-voltage side is armed, `hv_en_o` goes high only once `TOGGLE_COUNT` rising edges have been counted on `hv_toggle_i`.
- R3: The low-voltage counter and `lv_en_o` clear on the next clock edge if any of these holds: `ref_ok_i` = 0, `win_ok_i` = 0, `util_rst_ni` = 0, or `remote_rst_i` = 1. After a clear, a full `TOGGLE_COUNT` edges are needed again.
- R4: Every low-voltage clear also clears the high-voltage counter and `hv_en_o` in the same cycle.
- R5: `dig_ok_i` = 0 acts as a clear condition only while `dig_chk_en_i` = 1. With `dig_chk_en_i` = 0 it has no effect on either enable.
- R6: Both counters saturate at `TOGGLE_COUNT`. Further edges neither wrap a counter nor drop an enable.
- R7: `lv_force_i` = 1 drives `lv_en_o` high and `hv_force_i` = 1 drives `hv_en_o` high, combinationally and regardless of faults. Neither force input advances or arms a counter.
- R8: Edges on `hv_toggle_i` that occur while the low-voltage counter is not armed are discarded and do not advance the high-voltage counter.
- R9: When a clear condition and a counted edge fall on the same clock edge, the clear wins and the counter ends at zero.
- R10: While `rst_ni` is low, both counters are zero and both enables are low (with force inputs low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lv_toggle_i | input | 1 | Low-voltage arming command line (asynchronous) |
| hv_toggle_i | input | 1 | High-voltage arming command line (asynchronous) |
| ref_ok_i | input | 1 | Reference supply good, 1 = good |
| win_ok_i | input | 1 | Comparator window good, 1 = all analog supplies in range |
| util_rst_ni | input | 1 | Utility reset, active low |
| dig_ok_i | input | 1 | Digital supply in range, 1 = good |
| dig_chk_en_i | input | 1 | 1 = include digital-supply check in the clear logic |
| remote_rst_i | input | 1 | Reset request from remote board, active high |
| lv_force_i | input | 1 | Test override, forces low-voltage enable on |
| hv_force_i | input | 1 | Test override, forces high-voltage enable on |
| lv_en_o | output | 1 | Low-voltage pair enable |
| hv_en_o | output | 1 | High-voltage rail enable |

## Verification
A fault clear and the arming edge of a counter can land on the same clock edge, and the clear must win. The bench lines this up by sending 127 low-voltage edges and then raising the line once more. It raises `remote_rst_i` during exactly the cycle in which the synchronized edge pulse is active. It then checks that `lv_en_o` stays low. It also checks that a further 127 edges still leave the enable off, which shows the counter restarted from zero rather than keeping the last edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef struct packed {
    logic ref_bad;
    logic win_bad;
    logic util_rst;
    logic remote;
    logic dig_bad;
  } fault_t;

  function automatic logic fault_any(fault_t f);
    return |f;
  endfunction
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[g] <= 1'b0;
      else         sr_q[g] <= sr_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];
  end

  assign rise_o = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pwr_seq_arm_cnt.sv
module pwr_seq_arm_cnt #(
  parameter int unsigned N  = 128,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          armed_o
);
  localparam logic [CW-1:0] TERM = CW'(N);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;   // clear beats a counted edge
    else if (inc_i && cnt_q != TERM) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o   = cnt_q;
  assign armed_o = (cnt_q == TERM);
endmodule

// File: rtl/pwr_seq_fault.sv
module pwr_seq_fault
  import pwr_seq_pkg::*;
(
  input  logic ref_ok_i,
  input  logic win_ok_i,
  input  logic util_rst_ni,
  input  logic dig_ok_i,
  input  logic dig_chk_en_i,
  input  logic remote_rst_i,
  output logic clr_o
);
  fault_t f;

  always_comb begin
    f.ref_bad  = ~ref_ok_i;
    f.win_bad  = ~win_ok_i;
    f.util_rst = ~util_rst_ni;
    f.remote   = remote_rst_i;
    f.dig_bad  = dig_chk_en_i & ~dig_ok_i;
  end

  assign clr_o = fault_any(f);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int unsigned TOGGLE_COUNT = 128,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned CNT_W = $clog2(TOGGLE_COUNT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lv_toggle_i,
  input  logic hv_toggle_i,
  input  logic ref_ok_i,
  input  logic win_ok_i,
  input  logic util_rst_ni,
  input  logic dig_ok_i,
  input  logic dig_chk_en_i,
  input  logic remote_rst_i,
  input  logic lv_force_i,
  input  logic hv_force_i,
  output logic lv_en_o,
  output logic hv_en_o
);
  logic             lv_rise, hv_rise;
  logic             lv_clr;
  logic [CNT_W-1:0] lv_cnt, hv_cnt;
  logic             lv_armed, hv_armed;

  pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_lv_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(lv_toggle_i), .rise_o(lv_rise));

  pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_hv_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(hv_toggle_i), .rise_o(hv_rise));

  pwr_seq_fault u_fault (
    .ref_ok_i(ref_ok_i), .win_ok_i(win_ok_i), .util_rst_ni(util_rst_ni),
    .dig_ok_i(dig_ok_i), .dig_chk_en_i(dig_chk_en_i),
    .remote_rst_i(remote_rst_i), .clr_o(lv_clr));

  pwr_seq_arm_cnt #(.N(TOGGLE_COUNT)) u_lv_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lv_clr), .inc_i(lv_rise),
    .cnt_o(lv_cnt), .armed_o(lv_armed));

  // hv edges only count once lv is armed; any lv clear also wipes hv
  pwr_seq_arm_cnt #(.N(TOGGLE_COUNT)) u_hv_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lv_clr), .inc_i(hv_rise & lv_armed),
    .cnt_o(hv_cnt), .armed_o(hv_armed));

  assign lv_en_o = lv_armed | lv_force_i;
  assign hv_en_o = hv_armed | hv_force_i;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int unsigned N  = 128,
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lv_clr,
  input logic [CW-1:0] lv_cnt,
  input logic [CW-1:0] hv_cnt,
  input logic          lv_armed,
  input logic          hv_armed,
  input logic          lv_en_o,
  input logic          hv_en_o,
  input logic          lv_force_i,
  input logic          hv_force_i
);
  localparam logic [CW-1:0] TERM = CW'(N);

  assert_lv_arm_after_full_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv_armed) |-> $past(lv_cnt) == TERM - CW'(1));

  assert_hv_arm_after_full_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hv_armed) |-> $past(hv_cnt) == TERM - CW'(1));

  assert_fault_clears_lv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_clr |=> (lv_cnt == '0));

  assert_fault_clears_hv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_clr |=> (hv_cnt == '0) && (hv_en_o == hv_force_i));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv_cnt <= TERM) && (hv_cnt <= TERM));

  assert_sat_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv_armed && !lv_clr) |=> lv_armed);

  assert_hv_needs_lv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_cnt != '0) |-> lv_armed);

  assert_lv_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lv_force_i && !lv_armed) |-> !lv_en_o);

  assert_reset_idle_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (lv_cnt == '0) && (hv_cnt == '0));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N(TOGGLE_COUNT), .CW(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lv_clr(lv_clr), .lv_cnt(lv_cnt),
  .hv_cnt(hv_cnt), .lv_armed(lv_armed), .hv_armed(hv_armed),
  .lv_en_o(lv_en_o), .hv_en_o(hv_en_o), .lv_force_i(lv_force_i),
  .hv_force_i(hv_force_i));

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  localparam int N = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lv_tog = 0, hv_tog = 0;
  logic ref_ok = 1, win_ok = 1, util_rst_n = 1, dig_ok = 1, dig_chk = 0, rem_rst = 0;
  logic lv_frc = 0, hv_frc = 0;
  logic lv_en, hv_en;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.TOGGLE_COUNT(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lv_toggle_i(lv_tog), .hv_toggle_i(hv_tog),
    .ref_ok_i(ref_ok), .win_ok_i(win_ok), .util_rst_ni(util_rst_n),
    .dig_ok_i(dig_ok), .dig_chk_en_i(dig_chk), .remote_rst_i(rem_rst),
    .lv_force_i(lv_frc), .hv_force_i(hv_frc), .lv_en_o(lv_en), .hv_en_o(hv_en));

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b @%0t", req, act, exp, $time);
    end
  endtask

  // each edge: high 2 cycles, low 2 cycles; counted before the task returns
  task automatic tog_lv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lv_tog = 1; @(negedge clk); @(negedge clk) lv_tog = 0; @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic tog_hv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hv_tog = 1; @(negedge clk); @(negedge clk) hv_tog = 0; @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    ref_ok = 1; win_ok = 1; util_rst_n = 1; dig_ok = 1; dig_chk = 0; rem_rst = 0;
    lv_frc = 0; hv_frc = 0; lv_tog = 0; hv_tog = 0;
    @(negedge clk); @(negedge clk) rst_n = 1;
  endtask

  task automatic arm_all();
    tog_lv(N); tog_hv(N);
  endtask

  task automatic t_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check("R10 lv_en in reset", lv_en, 0);
    check("R10 hv_en in reset", hv_en, 0);
    rst_n = 1;
  endtask

  task automatic t_lv_arm();
    do_reset();
    tog_lv(N - 1);
    check("R1 lv_en after N-1 edges", lv_en, 0);
    tog_lv(1);
    check("R1 lv_en after N edges", lv_en, 1);
    check("R1 hv_en stays off", hv_en, 0);
  endtask

  task automatic t_hv_ignore_and_arm();
    do_reset();
    tog_hv(N);
    check("R8 hv_en with lv off", hv_en, 0);
    tog_lv(N);
    tog_hv(N - 1);
    check("R8 early hv edges discarded", hv_en, 0);
    tog_hv(1);
    check("R2 hv_en after N edges", hv_en, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    arm_all();
    tog_lv(N + 5);
    tog_hv(N + 5);
    check("R6 lv_en after extra edges", lv_en, 1);
    check("R6 hv_en after extra edges", hv_en, 1);
  endtask

  task automatic t_fault(int kind, string tag);
    do_reset();
    arm_all();
    @(negedge clk);
    case (kind)
      0: ref_ok = 0;
      1: win_ok = 0;
      2: util_rst_n = 0;
      default: rem_rst = 1;
    endcase
    @(negedge clk);
    check({"R3 lv_en cleared by ", tag}, lv_en, 0);
    check({"R4 hv_en cleared by ", tag}, hv_en, 0);
    ref_ok = 1; win_ok = 1; util_rst_n = 1; rem_rst = 0;
    tog_lv(N - 1);
    check({"R3 count restarted after ", tag}, lv_en, 0);
  endtask

  task automatic t_dig();
    do_reset();
    arm_all();
    @(negedge clk) dig_ok = 0;
    repeat (4) @(negedge clk);
    check("R5 dig fault ignored lv", lv_en, 1);
    check("R5 dig fault ignored hv", hv_en, 1);
    dig_chk = 1;
    @(negedge clk);
    check("R5 dig fault clears lv", lv_en, 0);
    check("R5 dig fault clears hv", hv_en, 0);
    dig_ok = 1;
  endtask

  task automatic t_force();
    do_reset();
    @(negedge clk) ref_ok = 0; lv_frc = 1;
    #1 check("R7 lv forced under fault", lv_en, 1);
    check("R7 hv not forced", hv_en, 0);
    hv_frc = 1;
    #1 check("R7 hv forced", hv_en, 1);
    @(negedge clk) lv_frc = 0; hv_frc = 0;
    #1 check("R7 lv released", lv_en, 0);
    check("R7 hv released", hv_en, 0);
    ref_ok = 1;
    tog_lv(N - 1);
    check("R7 force did not arm lv", lv_en, 0);
  endtask

  task automatic t_collision();
    do_reset();
    tog_lv(N - 1);
    @(negedge clk) lv_tog = 1;        // sync s0 next edge, s1 after, count third
    @(negedge clk);
    @(negedge clk) rem_rst = 1;      // pulse active during this cycle
    @(negedge clk) rem_rst = 0;
    check("R9 clear beats final edge", lv_en, 0);
    lv_tog = 0;
    @(negedge clk); @(negedge clk);
    tog_lv(N - 1);
    check("R9 counter restarted at zero", lv_en, 0);
    tog_lv(1);
    check("R9 rearm after full count", lv_en, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lv_arm();
    t_hv_ignore_and_arm();
    t_saturate();
    t_fault(0, "ref");
    t_fault(1, "win");
    t_fault(2, "util_rst");
    t_fault(3, "remote");
    t_dig();
    t_force();
    t_collision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule